// File: doc/BRIEF.md
# Grouped Interrupt Expansion Controller

This block fans a large set of peripheral interrupt sources into a small number of CPU interrupt lines. The sources are arranged in groups (16 groups of 8 by default). Each group keeps a sticky flag per source, an enable byte, and an acknowledge latch. Any group with an enabled, flagged source and a clear acknowledge latch drives its CPU line. A CPU-side stage latches the line as pending. It gates the pending line with a per-line mask and a global interrupt-off bit, and dispatches the lowest-numbered eligible line.

The vector is resolved late, in the dispatch cycle itself, from the live flag and enable state of the group. If software has disabled the source after the line was latched, nothing in the group may be both flagged and enabled. In that case the controller returns the group's first vector and marks the fetch as a fallback. This reproduces the spurious first-source interrupt that follows from changing a group's enables outside that group's own service routine. Dispatch saves the mask and the global-off bit on a small nesting stack and sets global-off. A return pulse restores both values.

Software reaches the block through a simple write port. The acknowledge register (address 0) is write-one-to-clear. The CPU mask is at address 1, the global-off bit at address 2, and the enable byte for group g at address NUM_GROUPS+g.

Top module: `grouped_irq_expander`

## Requirements
- R1: After reset, vec_valid is 0, every grp_line bit is 0, and cpu_int_off is 1; no dispatch occurs until software writes 0 to the global-off bit at address 2.
- R2: A one-cycle pulse on src_pulse[g*8+s] sets a sticky flag that stays set while the source is disabled or its group is acknowledged, until that source's vector is fetched.
- R3: Within a group, the lowest-numbered source that is both flagged and enabled (bit s of the enable byte at address NUM_GROUPS+g) wins; vec_idx = g*8 + s.
- R4: When several CPU lines are pending and unmasked at once, the lowest-numbered line is dispatched first.
- R5: A fetch clears the winning source's flag and sets the group's acknowledge latch; while the latch is set the group's line stays low and no further vector from that group is dispatched.
- R6: Writing 1 to bit g of address 0 clears group g's acknowledge latch, and all ones clears every group; grp_line[g] can rise no earlier than the cycle after the clear.
- R7: A pending line whose bit in the CPU mask (address 1) is 0 stays latched and is dispatched once the bit is set.
- R8: Dispatch sets cpu_int_off in the same edge as vec_valid; lines that become pending while it is set stay latched and are dispatched after 0 is written to address 2.
- R9: An irq_ret pulse restores the mask and global-off values saved by the most recent dispatch, so nested dispatches unwind in reverse order.
- R10: If the dispatched group has no source both flagged and enabled, vec_idx = g*8 + 0, vec_fallback is 1, and no flag is cleared.
- R11: With the line unmasked and interrupts on, vec_valid rises three clock edges after the edge that samples the source pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pulse | input | NUM_GROUPS*SRCS_PER_GROUP | One-cycle event pulses, source s of group g at bit g*SRCS_PER_GROUP+s |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | log2(NUM_GROUPS)+1 | Register address: 0 ack clear, 1 mask, 2 global-off, NUM_GROUPS+g enables |
| wr_data | input | NUM_GROUPS | Write data; enable writes use the low SRCS_PER_GROUP bits |
| irq_ret | input | 1 | Return-from-interrupt pulse |
| vec_valid | output | 1 | One-cycle pulse marking a vector fetch |
| vec_idx | output | VEC_W | Fetched vector, group*SRCS_PER_GROUP + source |
| vec_fallback | output | 1 | Fetch found no flagged and enabled source |
| grp_line | output | NUM_GROUPS | Registered per-group request lines |
| cpu_int_off | output | 1 | Global interrupt-off state |

## Verification
A flag that is lost or cleared on the wrong source shows up as a missing or wrong vec_idx within three edges of the next dispatch opportunity. A flag that is never cleared shows up as a repeated vector once the acknowledge is cleared. An acknowledge latch stuck high or low shows on grp_line one edge after the stimulus, and as a missing or extra vec_valid a further two edges later. A corrupted nesting stack only becomes visible after irq_ret, as a wrong cpu_int_off level or as a masked line being dispatched (or an unmasked one held). The directed tests therefore read those outputs right after each return.

// File: rtl/gix_pkg.sv
// gix_pkg: shared constants for the grouped interrupt expander.
// Assumes: register addresses below NUM_GROUPS are the control registers,
// and enable registers start at NUM_GROUPS.
package gix_pkg;
    localparam int DEF_NUM_GROUPS = 16;
    localparam int DEF_SRCS       = 8;
    localparam int DEF_NEST_DEPTH = 4;
    localparam int DEF_VEC_W      = 8;

    // Control register addresses (enable registers live at NUM_GROUPS+g)
    localparam int ADDR_ACK  = 0;
    localparam int ADDR_MASK = 1;
    localparam int ADDR_GOFF = 2;
endpackage

// File: rtl/gix_group_slice.sv
// gix_group_slice: one interrupt group. Holds sticky source flags, the
// enable byte and the acknowledge latch, drives the registered group line
// and reports the live winner for a vector fetch.
// Assumes: fetch is asserted only in the dispatch cycle of this group.
module gix_group_slice #(
    parameter int SRCS = 8,
    localparam int SW  = $clog2(SRCS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SRCS-1:0] src_pulse,
    input  logic            en_we,
    input  logic [SRCS-1:0] en_wdata,
    input  logic            ack_clr,
    input  logic            fetch,
    output logic            line_q,
    output logic            ack_q,
    output logic            hit,
    output logic [SW-1:0]   win_idx
);
    logic [SRCS-1:0] flag_q;
    logic [SRCS-1:0] en_q;
    logic [SRCS-1:0] cand;
    logic [SRCS-1:0] clr_mask;

    // Live candidates: flagged and enabled right now
    assign cand = flag_q & en_q;
    assign hit  = |cand;

    // Lowest-numbered candidate wins
    always_comb begin
        win_idx = '0;
        for (int i = SRCS - 1; i >= 0; i--) begin
            if (cand[i]) win_idx = SW'(i);
        end
    end

    // One-hot clear of the fetched source (none on a fallback fetch)
    always_comb begin
        clr_mask = '0;
        if (fetch && hit) clr_mask[win_idx] = 1'b1;
    end

    // Sticky flags: a new pulse beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_mask) | src_pulse;
    end

    // Enable byte written through the register port
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= en_wdata;
    end

    // Acknowledge latch: set by a fetch, cleared by software; fetch wins
    always_ff @(posedge clk) begin
        if (!rst_n)       ack_q <= 1'b0;
        else if (fetch)   ack_q <= 1'b1;
        else if (ack_clr) ack_q <= 1'b0;
    end

    // Registered group line, dropped at once in the fetch cycle
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= hit && !ack_q && !fetch;
    end
endmodule

// File: rtl/gix_cpu_gate.sv
// gix_cpu_gate: CPU-side pending latches, line mask, global interrupt-off
// bit and the nesting stack that a return pulse unwinds.
// Assumes: nesting never exceeds DEPTH; a deeper dispatch is not saved.
module gix_cpu_gate #(
    parameter int NG    = 16,
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(NG),
    localparam int SPW  = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NG-1:0] grp_line,
    input  logic          mask_we,
    input  logic          goff_we,
    input  logic [NG-1:0] wdata,
    input  logic          irq_ret,
    output logic          take,
    output logic [LW-1:0] take_line,
    output logic          goff_q,
    output logic [NG-1:0] mask_q
);
    logic [NG-1:0]  pend_q;
    logic [NG-1:0]  eligible;
    logic [NG-1:0]  take_clr;
    logic [NG-1:0]  save_mask [DEPTH];
    logic [DEPTH-1:0] save_goff;
    logic [SPW-1:0] sp_q;
    logic [SPW-1:0] sp_dec;
    logic           can_pop;

    assign eligible = pend_q & mask_q;
    assign take     = (|eligible) && !goff_q && !irq_ret;
    assign can_pop  = irq_ret && (sp_q != '0);
    assign sp_dec   = sp_q - 1'b1;

    // Lowest-numbered eligible line is dispatched
    always_comb begin
        take_line = '0;
        for (int i = NG - 1; i >= 0; i--) begin
            if (eligible[i]) take_line = LW'(i);
        end
    end

    // Clear mask for the line being taken
    always_comb begin
        take_clr = '0;
        if (take) take_clr[take_line] = 1'b1;
    end

    // Pending latches: set by a group line, cleared on dispatch
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q | grp_line) & ~take_clr;
    end

    // Global-off, mask and nesting stack; return beats dispatch beats write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            goff_q    <= 1'b1;
            mask_q    <= '0;
            sp_q      <= '0;
            save_goff <= '0;
            for (int d = 0; d < DEPTH; d++) save_mask[d] <= '0;
        end else if (can_pop) begin
            goff_q <= save_goff[sp_dec[IW-1:0]];
            mask_q <= save_mask[sp_dec[IW-1:0]];
            sp_q   <= sp_dec;
        end else begin
            if (take) begin
                goff_q <= 1'b1;
                if (sp_q != SPW'(DEPTH)) begin
                    save_goff[sp_q[IW-1:0]] <= goff_q;
                    save_mask[sp_q[IW-1:0]] <= mask_q;
                    sp_q <= sp_q + 1'b1;
                end
            end else if (goff_we) begin
                goff_q <= wdata[0];
            end
            if (mask_we) mask_q <= wdata;
        end
    end
endmodule

// File: rtl/grouped_irq_expander.sv
// grouped_irq_expander: top level. Decodes the register write port,
// instantiates one slice per group and the CPU gate, and registers the
// late-resolved vector in the dispatch cycle.
// Assumes: SRCS_PER_GROUP <= NUM_GROUPS (enables use low write-data bits),
// NUM_GROUPS >= 3 so control addresses do not overlap enable addresses.
module grouped_irq_expander
    import gix_pkg::*;
#(
    parameter int NUM_GROUPS     = DEF_NUM_GROUPS,
    parameter int SRCS_PER_GROUP = DEF_SRCS,
    parameter int NEST_DEPTH     = DEF_NEST_DEPTH,
    parameter int VEC_W          = DEF_VEC_W,
    localparam int LW     = $clog2(NUM_GROUPS),
    localparam int SW     = $clog2(SRCS_PER_GROUP),
    localparam int NSRC   = NUM_GROUPS * SRCS_PER_GROUP,
    localparam int ADDR_W = LW + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       src_pulse,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [NUM_GROUPS-1:0] wr_data,
    input  logic                  irq_ret,
    output logic                  vec_valid,
    output logic [VEC_W-1:0]      vec_idx,
    output logic                  vec_fallback,
    output logic [NUM_GROUPS-1:0] grp_line,
    output logic                  cpu_int_off
);
    logic                  ack_wr;
    logic                  mask_wr;
    logic                  goff_wr;
    logic                  take;
    logic [LW-1:0]         take_line;
    logic [NUM_GROUPS-1:0] ack_all;
    logic [NUM_GROUPS-1:0] hit_v;
    logic [SW-1:0]         win_v [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] cpu_mask;
    logic                  hit_sel;
    logic [SW-1:0]         src_sel;

    // Control register decode
    assign ack_wr  = wr_en && (wr_addr == ADDR_W'(ADDR_ACK));
    assign mask_wr = wr_en && (wr_addr == ADDR_W'(ADDR_MASK));
    assign goff_wr = wr_en && (wr_addr == ADDR_W'(ADDR_GOFF));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_slice
        logic en_we;
        logic fetch;
        // Per-group enable decode and fetch select
        assign en_we = wr_en && (wr_addr == ADDR_W'(NUM_GROUPS + g));
        assign fetch = take && (take_line == LW'(g));

        gix_group_slice #(.SRCS(SRCS_PER_GROUP)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_pulse(src_pulse[g*SRCS_PER_GROUP +: SRCS_PER_GROUP]),
            .en_we    (en_we),
            .en_wdata (wr_data[SRCS_PER_GROUP-1:0]),
            .ack_clr  (ack_wr && wr_data[g]),
            .fetch    (fetch),
            .line_q   (grp_line[g]),
            .ack_q    (ack_all[g]),
            .hit      (hit_v[g]),
            .win_idx  (win_v[g])
        );
    end

    gix_cpu_gate #(.NG(NUM_GROUPS), .DEPTH(NEST_DEPTH)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .grp_line (grp_line),
        .mask_we  (mask_wr),
        .goff_we  (goff_wr),
        .wdata    (wr_data),
        .irq_ret  (irq_ret),
        .take     (take),
        .take_line(take_line),
        .goff_q   (cpu_int_off),
        .mask_q   (cpu_mask)
    );

    // Late vector resolution from the live state of the taken group
    assign hit_sel = hit_v[take_line];
    assign src_sel = hit_sel ? win_v[take_line] : '0;

    // Registered vector outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid    <= 1'b0;
            vec_idx      <= '0;
            vec_fallback <= 1'b0;
        end else begin
            vec_valid    <= take;
            vec_fallback <= take && !hit_sel;
            if (take) vec_idx <= VEC_W'({take_line, src_sel});
        end
    end
endmodule

// File: rtl/gix_checker.sv
// gix_checker: temporal properties of the expander, bound to the top.
module gix_checker #(
    parameter int NUM_GROUPS     = 16,
    parameter int SRCS_PER_GROUP = 8,
    parameter int VEC_W          = 8,
    localparam int LW = $clog2(NUM_GROUPS),
    localparam int SW = $clog2(SRCS_PER_GROUP)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  vec_valid,
    input logic [VEC_W-1:0]      vec_idx,
    input logic                  vec_fallback,
    input logic [NUM_GROUPS-1:0] grp_line,
    input logic                  cpu_int_off,
    input logic [NUM_GROUPS-1:0] ack_all,
    input logic [NUM_GROUPS-1:0] cpu_mask
);
    // R1: reset leaves the outputs quiet and interrupts off
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!vec_valid && grp_line == '0 && cpu_int_off));

    // R8: a fetch needs interrupts on before, and turns them off
    assert_take_needs_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (cpu_int_off && !$past(cpu_int_off)));

    // R10: a fallback fetch always points at source 0
    assert_fallback_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_fallback) |-> (vec_idx[SW-1:0] == '0));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        // R5: a fetch from group g leaves its acknowledge set
        assert_ack_on_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (vec_valid && vec_idx[SW +: LW] == LW'(g)) |-> ack_all[g]);
        // R6: the line is high only if the acknowledge was clear a cycle earlier
        assert_line_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
            grp_line[g] |-> !$past(ack_all[g]));
        // R7: a line is dispatched only while its mask bit was set
        assert_mask_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (vec_valid && vec_idx[SW +: LW] == LW'(g)) |-> $past(cpu_mask[g]));
    end
endmodule

bind grouped_irq_expander gix_checker #(
    .NUM_GROUPS    (NUM_GROUPS),
    .SRCS_PER_GROUP(SRCS_PER_GROUP),
    .VEC_W         (VEC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vec_valid   (vec_valid),
    .vec_idx     (vec_idx),
    .vec_fallback(vec_fallback),
    .grp_line    (grp_line),
    .cpu_int_off (cpu_int_off),
    .ack_all     (ack_all),
    .cpu_mask    (cpu_mask)
);

// File: tb/sim_grouped_irq_expander.sv
// Directed bench for grouped_irq_expander: one task per scenario.
module sim_grouped_irq_expander;
    localparam int NG = 16;
    localparam int NS = 8;
    localparam int AW = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NG*NS-1:0] src_pulse = '0;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [NG-1:0]  wr_data = '0;
    logic           irq_ret = 1'b0;
    logic           vec_valid;
    logic [7:0]     vec_idx;
    logic           vec_fallback;
    logic [NG-1:0]  grp_line;
    logic           cpu_int_off;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    grouped_irq_expander u0 (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_ret(irq_ret), .vec_valid(vec_valid), .vec_idx(vec_idx),
        .vec_fallback(vec_fallback), .grp_line(grp_line),
        .cpu_int_off(cpu_int_off)
    );

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: cycles %0d expected below %0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = NG'(data);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int g, input int bits);
        src_pulse[g*NS +: NS] = NS'(bits);
        tick();
        src_pulse = '0;
    endtask

    task automatic ret();
        irq_ret = 1'b1;
        tick();
        irq_ret = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic open_all();
        for (int g = 0; g < NG; g++) wr(NG + g, 8'hFF);
        wr(1, 16'hFFFF);
    endtask

    task automatic run_cap(input int n, output int got, output int idx, output int fb);
        got = 0; idx = -1; fb = -1;
        for (int i = 0; i < n; i++) begin
            tick();
            if (vec_valid && got == 0) begin
                got = 1; idx = int'(vec_idx); fb = int'(vec_fallback);
            end
        end
    endtask

    task automatic t_reset();
        int got, idx, fb;
        do_reset();
        chk("R1", "vec_valid", int'(vec_valid), 0);
        chk("R1", "grp_line", int'(grp_line), 0);
        chk("R1", "cpu_int_off", int'(cpu_int_off), 1);
        open_all();
        pulse(0, 8'h01);
        run_cap(6, got, idx, fb);
        chk("R1", "dispatch while off", got, 0);
        chk("R2", "line from held flag", int'(grp_line[0]), 1);
    endtask

    task automatic t_latency();
        do_reset();
        open_all();
        wr(2, 0);
        pulse(1, 8'h10);
        chk("R11", "valid edge 1", int'(vec_valid), 0);
        tick();
        chk("R11", "valid edge 2", int'(vec_valid), 0);
        chk("R11", "line edge 2", int'(grp_line[1]), 1);
        tick();
        chk("R11", "valid edge 3", int'(vec_valid), 0);
        tick();
        chk("R11", "valid edge 4", int'(vec_valid), 1);
        chk("R11", "vec_idx", int'(vec_idx), 12);
        chk("R10", "normal fetch fallback", int'(vec_fallback), 0);
        chk("R8", "int off after take", int'(cpu_int_off), 1);
        chk("R5", "line low after fetch", int'(grp_line[1]), 0);
    endtask

    task automatic t_in_group();
        int got, idx, fb;
        do_reset();
        wr(NG + 3, 8'h24);
        wr(1, 16'hFFFF);
        pulse(3, 8'h26);
        wr(2, 0);
        run_cap(6, got, idx, fb);
        chk("R3", "lowest enabled source", idx, 26);
        wr(2, 0);
        run_cap(8, got, idx, fb);
        chk("R5", "held by ack", got, 0);
        chk("R5", "line held low", int'(grp_line[3]), 0);
        wr(0, 16'h0008);
        chk("R6", "line same edge as clear", int'(grp_line[3]), 0);
        tick();
        chk("R6", "line one edge later", int'(grp_line[3]), 1);
        run_cap(4, got, idx, fb);
        chk("R3", "next source", idx, 29);
        wr(2, 0);
        wr(NG + 3, 8'h26);
        wr(0, 16'hFFFF);
        run_cap(6, got, idx, fb);
        chk("R2", "disabled flag kept", idx, 25);
        chk("R6", "all-ones clear dispatches", got, 1);
    endtask

    task automatic t_cross_group();
        int got, idx, fb;
        do_reset();
        open_all();
        src_pulse[5*NS + 1] = 1'b1;
        src_pulse[2*NS + 6] = 1'b1;
        tick();
        src_pulse = '0;
        tick(); tick(); tick();
        wr(2, 0);
        run_cap(3, got, idx, fb);
        chk("R4", "lower line first", idx, 22);
        wr(2, 0);
        run_cap(3, got, idx, fb);
        chk("R4", "higher line second", idx, 41);
    endtask

    task automatic t_mask();
        int got, idx, fb;
        do_reset();
        open_all();
        wr(1, 16'hFFEF);
        wr(2, 0);
        pulse(4, 8'h01);
        run_cap(8, got, idx, fb);
        chk("R7", "masked line held", got, 0);
        chk("R7", "line still requesting", int'(grp_line[4]), 1);
        wr(1, 16'hFFFF);
        run_cap(3, got, idx, fb);
        chk("R7", "unmasked dispatch", idx, 32);
    endtask

    task automatic t_goff();
        int got, idx, fb;
        do_reset();
        open_all();
        wr(2, 0);
        pulse(6, 8'h04);
        run_cap(5, got, idx, fb);
        chk("R8", "first dispatch", idx, 50);
        chk("R8", "off after take", int'(cpu_int_off), 1);
        pulse(7, 8'h02);
        run_cap(8, got, idx, fb);
        chk("R8", "held while off", got, 0);
        wr(2, 0);
        run_cap(3, got, idx, fb);
        chk("R8", "served after on", idx, 57);
    endtask

    task automatic t_nest();
        int got, idx, fb;
        do_reset();
        for (int g = 0; g < NG; g++) wr(NG + g, 8'hFF);
        wr(1, 16'h0009);
        wr(2, 0);
        pulse(3, 8'h01);
        run_cap(5, got, idx, fb);
        chk("R9", "outer dispatch", idx, 24);
        wr(1, 16'h0001);
        wr(2, 0);
        pulse(0, 8'h80);
        run_cap(5, got, idx, fb);
        chk("R9", "nested dispatch", idx, 7);
        ret();
        chk("R9", "inner return int on", int'(cpu_int_off), 0);
        wr(0, 16'h0008);
        pulse(3, 8'h04);
        run_cap(6, got, idx, fb);
        chk("R9", "inner mask restored", got, 0);
        ret();
        run_cap(3, got, idx, fb);
        chk("R9", "outer mask restored", idx, 26);
    endtask

    task automatic t_spurious();
        int got, idx, fb;
        do_reset();
        open_all();
        pulse(2, 8'h08);
        tick(); tick(); tick();
        wr(NG + 2, 0);
        wr(2, 0);
        run_cap(3, got, idx, fb);
        chk("R10", "fallback vector", idx, 16);
        chk("R10", "fallback marked", fb, 1);
        chk("R10", "line low", int'(grp_line[2]), 0);
        wr(NG + 2, 8'hFF);
        wr(2, 0);
        wr(0, 16'h0004);
        run_cap(5, got, idx, fb);
        chk("R10", "flag not cleared", idx, 19);
        chk("R10", "real fetch unmarked", fb, 0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_in_group();
        t_cross_group();
        t_mask();
        t_goff();
        t_nest();
        t_spurious();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule